// File: doc/BRIEF.md
# Pipelined Scan Sequencer with Calibration Lookup

This block sequences a multiplexed acquisition front end through a list of channels, one channel per fixed-length measurement cycle. At each cycle boundary it selects the next channel from a channel-list memory and drives it onto the multiplexer. In the same clock it fires the converter start for the channel that was selected one cycle earlier. While the new channel settles, an autorange walker begins at the widest range and steps toward finer ranges as long as the range comparator reports the signal below a quarter of full scale.

Once the range is settled, the block reads that channel's entry for the chosen range from a calibration RAM. It then loads the gain constant, the coarse offset constant and the fine offset constant into the correction DAC registers, so that the converter sees a corrected signal. If the walk and the load cannot finish inside the cycle, the next conversion still starts on time: it is marked with an overrun flag and carries the range that had been reached. A scan-start pulse flushes the pipeline and restarts the list from its first entry.

Top module: `acq_scan_ctrl`

## Requirements
- R1: After reset, and until the first scan_start, mux_load, adc_start, cal_rd, dac_ld and overrun stay low, and mux_ch, range_sel and the DAC outputs are 0. The range_under input has no effect on range_sel during this time.
- R2: The first mux_load pulse comes one clock after a scan_start clock, and further pulses follow every CYCLE_CLKS clocks. With each pulse, mux_ch takes the value list_data shows for list_addr in that clock (a combinational read), and list_addr steps to the next entry. After the entry at index list_last, list_addr returns to 0.
- R3: adc_start pulses in the same clock as every mux_load except the first one after a scan_start. With it, adc_ch gives the channel selected in the cycle before, and adc_range gives the final range of that channel.
- R4: range_sel returns to 0 (the widest range; larger codes are finer, up to N_RNG-1) in the clock of each mux_load. SETTLE_CLKS clocks after each range change, the block samples range_under. If it is high and range_sel is below N_RNG-1, range_sel rises by exactly 1 and a new settle period starts. Otherwise the walk ends.
- R5: In the clock after the walk ends, cal_rd is high for exactly one clock, with cal_addr = channel × N_RNG + range_sel. For a channel that steps m times, this falls SETTLE_CLKS × (m+1) clocks after its mux_load.
- R6: Two clocks after cal_rd, dac_ld pulses for one clock. The DAC outputs take the calibration word returned one clock after cal_rd: dac_gain = bits [31:20], dac_coarse = bits [19:12], dac_fine = bits [11:0]. Between loads the DAC outputs hold their values.
- R7: If dac_ld for a channel would fall in or after the clock of the next mux_load, no load takes place for that channel. Instead, overrun pulses together with that channel's adc_start, and adc_range gives the range reached.
- R8: A scan_start in the middle of a scan abandons the channel in flight, with no cal read or DAC load for it. It resets the list pointer to 0, gives a mux_load one clock later, and gives no adc_start with that mux_load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_start | input | 1 | Start or restart the scan at list entry 0 |
| list_last | input | PTR_W | Index of the last used channel-list entry |
| list_addr | output | PTR_W | Channel-list memory address |
| list_data | input | CH_W | Channel number stored at list_addr |
| mux_ch | output | CH_W | Channel driven to the multiplexer |
| mux_load | output | 1 | One-clock strobe: multiplexer advanced |
| range_sel | output | RNG_W | Amplifier range, 0 widest |
| range_under | input | 1 | Comparator: signal below a quarter of full scale |
| cal_rd | output | 1 | Calibration RAM read strobe |
| cal_addr | output | CAL_AW | Calibration RAM address |
| cal_data | input | 32 | Calibration word, valid one clock after cal_rd |
| dac_gain | output | 12 | Gain correction DAC register |
| dac_coarse | output | 8 | Coarse offset DAC register |
| dac_fine | output | 12 | Fine offset DAC register |
| dac_ld | output | 1 | One-clock DAC load strobe |
| adc_start | output | 1 | Converter start pulse |
| adc_ch | output | CH_W | Channel being converted |
| adc_range | output | RNG_W | Range used for that conversion |
| overrun | output | 1 | Conversion started before the calibration load finished |

## Verification
Two functions share a clock by design: the converter start for channel k falls on the same edge as the multiplexer advance to channel k+1. Each cycle check samples both strobes together with adc_ch, adc_range and mux_ch. The DAC load of a slow channel can also fall on the cycle boundary itself. A channel whose level forces the walk down to the finest range is provoked with a 22-clock cycle and 4 settle clocks, which puts its load exactly on the next multiplexer edge. That case is judged by overrun arriving with the converter start, by the absence of dac_ld, and by the DAC outputs keeping the previous channel's constants.

// File: rtl/acq_scan_pkg.sv
package acq_scan_pkg;

    localparam int GAIN_W     = 12;
    localparam int COARSE_W   = 8;
    localparam int FINE_W     = 12;
    localparam int CAL_WORD_W = GAIN_W + COARSE_W + FINE_W;

    // Calibration word, most significant field first
    typedef struct packed {
        logic [GAIN_W-1:0]   gain;
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
    } cal_word_t;

    typedef enum logic [2:0] {
        RG_IDLE,
        RG_SETTLE,
        RG_READ,
        RG_CAPT,
        RG_DONE
    } rg_state_e;

    function automatic int cal_index(input int ch, input int rng, input int n_rng);
        return ch * n_rng + rng;
    endfunction

endpackage

// File: rtl/acq_cycle_timer.sv
module acq_cycle_timer #(
    parameter int CYCLE_CLKS = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic scan_start,
    output logic tick
);
    localparam int CNT_W = $clog2(CYCLE_CLKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLE_CLKS - 1);

    logic             run;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (scan_start) begin
            run <= 1'b1;
            cnt <= LAST;
        end else if (run) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign tick = run && !scan_start && (cnt == LAST);

endmodule

// File: rtl/acq_list_walker.sv
module acq_list_walker #(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scan_start,
    input  logic             tick,
    input  logic [PTR_W-1:0] list_last,
    output logic [PTR_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst || scan_start) begin
            ptr <= '0;
        end else if (tick) begin
            ptr <= (ptr >= list_last) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/acq_autorange.sv
module acq_autorange
    import acq_scan_pkg::*;
#(
    parameter int N_CH        = 64,
    parameter int N_RNG       = 5,
    parameter int SETTLE_CLKS = 100,
    parameter int CH_W        = 6,
    parameter int RNG_W       = 3,
    parameter int CAL_AW      = 9
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scan_start,
    input  logic                  tick,
    input  logic [CH_W-1:0]       cur_ch,
    input  logic                  range_under,
    output logic [RNG_W-1:0]      range_sel,
    output logic                  cal_rd,
    output logic [CAL_AW-1:0]     cal_addr,
    input  logic [CAL_WORD_W-1:0] cal_data,
    output cal_word_t             dac_word,
    output logic                  dac_ld,
    output logic                  done
);
    localparam int SET_W = $clog2(SETTLE_CLKS + 1);
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CLKS - 1);
    localparam logic [RNG_W-1:0] RNG_MAX  = RNG_W'(N_RNG - 1);

    rg_state_e        st;
    logic [SET_W-1:0] settle;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= RG_IDLE;
            settle    <= '0;
            range_sel <= '0;
            cal_rd    <= 1'b0;
            cal_addr  <= '0;
            dac_ld    <= 1'b0;
            dac_word  <= '0;
        end else begin
            cal_rd <= 1'b0;
            dac_ld <= 1'b0;
            if (scan_start) begin
                st        <= RG_IDLE;
                range_sel <= '0;
            end else if (tick) begin
                st        <= RG_SETTLE;
                range_sel <= '0;
                settle    <= SET_LAST;
            end else begin
                case (st)
                    RG_SETTLE: begin
                        if (settle != '0) begin
                            settle <= settle - 1'b1;
                        end else if (range_under && range_sel != RNG_MAX) begin
                            range_sel <= range_sel + 1'b1;
                            settle    <= SET_LAST;
                        end else begin
                            st       <= RG_READ;
                            cal_rd   <= 1'b1;
                            cal_addr <= CAL_AW'(cal_index(int'(cur_ch), int'(range_sel), N_RNG));
                        end
                    end
                    RG_READ: st <= RG_CAPT;
                    RG_CAPT: begin
                        dac_word <= cal_word_t'(cal_data);
                        dac_ld   <= 1'b1;
                        st       <= RG_DONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign done = (st == RG_DONE);

endmodule

// File: rtl/acq_scan_ctrl.sv
module acq_scan_ctrl
    import acq_scan_pkg::*;
#(
    parameter int N_CH        = 64,
    parameter int N_RNG       = 5,
    parameter int LIST_DEPTH  = 64,
    parameter int CYCLE_CLKS  = 1000,
    parameter int SETTLE_CLKS = 100,
    localparam int CH_W   = $clog2(N_CH),
    localparam int RNG_W  = $clog2(N_RNG),
    localparam int PTR_W  = $clog2(LIST_DEPTH),
    localparam int CAL_AW = $clog2(N_CH * N_RNG)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scan_start,
    input  logic [PTR_W-1:0]      list_last,
    output logic [PTR_W-1:0]      list_addr,
    input  logic [CH_W-1:0]       list_data,
    output logic [CH_W-1:0]       mux_ch,
    output logic                  mux_load,
    output logic [RNG_W-1:0]      range_sel,
    input  logic                  range_under,
    output logic                  cal_rd,
    output logic [CAL_AW-1:0]     cal_addr,
    input  logic [CAL_WORD_W-1:0] cal_data,
    output logic [GAIN_W-1:0]     dac_gain,
    output logic [COARSE_W-1:0]   dac_coarse,
    output logic [FINE_W-1:0]     dac_fine,
    output logic                  dac_ld,
    output logic                  adc_start,
    output logic [CH_W-1:0]       adc_ch,
    output logic [RNG_W-1:0]      adc_range,
    output logic                  overrun
);
    logic      tick;
    logic      done;
    logic      have_prev;
    cal_word_t dac_word;

    acq_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .scan_start (scan_start),
        .tick       (tick)
    );

    acq_list_walker #(.PTR_W(PTR_W)) u_walker (
        .clk        (clk),
        .rst        (rst),
        .scan_start (scan_start),
        .tick       (tick),
        .list_last  (list_last),
        .ptr        (list_addr)
    );

    acq_autorange #(
        .N_CH        (N_CH),
        .N_RNG       (N_RNG),
        .SETTLE_CLKS (SETTLE_CLKS),
        .CH_W        (CH_W),
        .RNG_W       (RNG_W),
        .CAL_AW      (CAL_AW)
    ) u_range (
        .clk         (clk),
        .rst         (rst),
        .scan_start  (scan_start),
        .tick        (tick),
        .cur_ch      (mux_ch),
        .range_under (range_under),
        .range_sel   (range_sel),
        .cal_rd      (cal_rd),
        .cal_addr    (cal_addr),
        .cal_data    (cal_data),
        .dac_word    (dac_word),
        .dac_ld      (dac_ld),
        .done        (done)
    );

    // Cycle boundary: advance the mux and start the previous channel's conversion
    always_ff @(posedge clk) begin
        if (rst) begin
            mux_ch    <= '0;
            mux_load  <= 1'b0;
            adc_start <= 1'b0;
            adc_ch    <= '0;
            adc_range <= '0;
            overrun   <= 1'b0;
            have_prev <= 1'b0;
        end else begin
            mux_load  <= 1'b0;
            adc_start <= 1'b0;
            overrun   <= 1'b0;
            if (scan_start) begin
                have_prev <= 1'b0;
            end else if (tick) begin
                mux_ch    <= list_data;
                mux_load  <= 1'b1;
                have_prev <= 1'b1;
                adc_start <= have_prev;
                overrun   <= have_prev && !done;
                if (have_prev) begin
                    adc_ch    <= mux_ch;
                    adc_range <= range_sel;
                end
            end
        end
    end

    assign dac_gain   = dac_word.gain;
    assign dac_coarse = dac_word.coarse;
    assign dac_fine   = dac_word.fine;

endmodule

// File: rtl/acq_scan_chk.sv
module acq_scan_chk #(
    parameter int N_CH   = 64,
    parameter int N_RNG  = 5,
    parameter int RNG_W  = 3,
    parameter int CAL_AW = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              mux_load,
    input logic              adc_start,
    input logic              overrun,
    input logic              cal_rd,
    input logic [CAL_AW-1:0] cal_addr,
    input logic              dac_ld,
    input logic [RNG_W-1:0]  range_sel
);
    assert_adc_rides_mux_R3: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> mux_load);

    assert_overrun_with_start_R7: assert property (@(posedge clk) disable iff (rst)
        overrun |-> adc_start);

    assert_no_load_on_boundary_R7: assert property (@(posedge clk) disable iff (rst)
        mux_load |-> !dac_ld);

    assert_load_follows_read_R6: assert property (@(posedge clk) disable iff (rst)
        dac_ld |-> $past(cal_rd, 2));

    assert_range_restart_R4: assert property (@(posedge clk) disable iff (rst)
        mux_load |-> (range_sel == '0));

    assert_range_single_step_R4: assert property (@(posedge clk) disable iff (rst)
        (range_sel != $past(range_sel)) |->
            ((range_sel == RNG_W'($past(range_sel) + 1'b1)) || (range_sel == '0)));

    assert_range_bound_R4: assert property (@(posedge clk) disable iff (rst)
        int'(range_sel) <= N_RNG - 1);

    assert_addr_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cal_rd |-> (int'(cal_addr) < N_CH * N_RNG));

endmodule

bind acq_scan_ctrl acq_scan_chk #(
    .N_CH   (N_CH),
    .N_RNG  (N_RNG),
    .RNG_W  (RNG_W),
    .CAL_AW (CAL_AW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mux_load  (mux_load),
    .adc_start (adc_start),
    .overrun   (overrun),
    .cal_rd    (cal_rd),
    .cal_addr  (cal_addr),
    .dac_ld    (dac_ld),
    .range_sel (range_sel)
);

// File: tb/sim_acq_scan_ctrl.sv
module sim_acq_scan_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N_CH   = 64;
    localparam int N_RNG  = 5;
    localparam int DEPTH  = 64;
    localparam int CYC    = 22;
    localparam int SET    = 4;
    localparam int CH_W   = 6;
    localparam int RNG_W  = 3;
    localparam int PTR_W  = 6;
    localparam int CAL_AW = 9;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              scan_start = 1'b0;
    logic [PTR_W-1:0]  list_last = '0;
    logic [PTR_W-1:0]  list_addr;
    logic [CH_W-1:0]   list_data;
    logic [CH_W-1:0]   mux_ch;
    logic              mux_load;
    logic [RNG_W-1:0]  range_sel;
    logic              range_under;
    logic              cal_rd;
    logic [CAL_AW-1:0] cal_addr;
    logic [31:0]       cal_data = '0;
    logic [11:0]       dac_gain;
    logic [7:0]        dac_coarse;
    logic [11:0]       dac_fine;
    logic              dac_ld;
    logic              adc_start;
    logic [CH_W-1:0]   adc_ch;
    logic [RNG_W-1:0]  adc_range;
    logic              overrun;

    logic [CH_W-1:0] list_mem [DEPTH];
    int              lvl [N_CH];

    int n_chk = 0;
    int n_bad = 0;

    bit prev_valid = 0;
    int prev_ch = 0;
    int prev_m = 0;
    bit prev_ovr = 0;
    int exp_ptr = 0;
    int last_g = 0;
    int last_c = 0;
    int last_f = 0;

    acq_scan_ctrl #(
        .N_CH        (N_CH),
        .N_RNG       (N_RNG),
        .LIST_DEPTH  (DEPTH),
        .CYCLE_CLKS  (CYC),
        .SETTLE_CLKS (SET)
    ) u0 (
        .clk         (clk),
        .rst         (rst),
        .scan_start  (scan_start),
        .list_last   (list_last),
        .list_addr   (list_addr),
        .list_data   (list_data),
        .mux_ch      (mux_ch),
        .mux_load    (mux_load),
        .range_sel   (range_sel),
        .range_under (range_under),
        .cal_rd      (cal_rd),
        .cal_addr    (cal_addr),
        .cal_data    (cal_data),
        .dac_gain    (dac_gain),
        .dac_coarse  (dac_coarse),
        .dac_fine    (dac_fine),
        .dac_ld      (dac_ld),
        .adc_start   (adc_start),
        .adc_ch      (adc_ch),
        .adc_range   (adc_range),
        .overrun     (overrun)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Channel-list memory, combinational read
    assign list_data = list_mem[list_addr];

    // Comparator model: full scale of range r is 4096 >> 2r units
    always_comb range_under = (lvl[mux_ch] * 4) < (4096 >> (2 * int'(range_sel)));

    function automatic int fld_g(input int a); return (a * 37 + 5) % 4096; endfunction
    function automatic int fld_c(input int a); return (a * 11 + 3) % 256;  endfunction
    function automatic int fld_f(input int a); return (a * 101 + 7) % 4096; endfunction

    // Calibration RAM model: one clock of read latency
    always @(posedge clk)
        if (cal_rd)
            cal_data <= {12'(fld_g(int'(cal_addr))), 8'(fld_c(int'(cal_addr))), 12'(fld_f(int'(cal_addr)))};

    function automatic int exp_steps(input int l);
        int r = 0;
        while (r < N_RNG - 1 && l * 4 < (4096 >> (2 * r))) r++;
        return r;
    endfunction

    task automatic check_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic start_scan();
        @(negedge clk) scan_start = 1'b1;
        @(negedge clk) scan_start = 1'b0;
        check_eq("R8 no mux_load in start clock", int'(mux_load), 0);
        @(negedge clk);
        check_eq("R8 mux_load one clock after start", int'(mux_load), 1);
        prev_valid = 0;
        exp_ptr = 0;
    endtask

    // Entered at the negedge where mux_load is high; leaves at the next one
    task automatic step_cycle();
        int ch, m, k_dec, k_ld, a;
        bit ovr;
        ch = int'(list_mem[exp_ptr]);
        m = exp_steps(lvl[ch]);
        k_dec = SET * (m + 1);
        k_ld = k_dec + 2;
        ovr = (k_ld >= CYC);
        a = ch * N_RNG + m;
        check_eq("R2 mux_load at boundary", int'(mux_load), 1);
        check_eq("R2 mux_ch from list", int'(mux_ch), ch);
        check_eq("R4 range restarts at 0", int'(range_sel), 0);
        check_eq("R3 adc_start with mux advance", int'(adc_start), int'(prev_valid));
        if (prev_valid) begin
            check_eq("R3 adc_ch is previous channel", int'(adc_ch), prev_ch);
            check_eq("R3 adc_range of previous channel", int'(adc_range), prev_m);
            check_eq("R7 overrun flag", int'(overrun), int'(prev_ovr));
        end else begin
            check_eq("R7 no overrun without conversion", int'(overrun), 0);
        end
        for (int k = 1; k < CYC; k++) begin
            @(negedge clk);
            if (k % SET == 0)
                check_eq("R4 range walk", int'(range_sel), (k / SET < m) ? k / SET : m);
            if (k == k_dec) begin
                check_eq("R5 cal_rd after walk", int'(cal_rd), 1);
                check_eq("R5 cal_addr", int'(cal_addr), a);
            end else if (cal_rd) begin
                check_eq("R5 stray cal_rd", 1, 0);
            end
            if (k == k_ld) begin
                check_eq("R6 dac_ld two clocks after read", int'(dac_ld), 1);
                check_eq("R6 gain field", int'(dac_gain), fld_g(a));
                check_eq("R6 coarse field", int'(dac_coarse), fld_c(a));
                check_eq("R6 fine field", int'(dac_fine), fld_f(a));
                last_g = fld_g(a);
                last_c = fld_c(a);
                last_f = fld_f(a);
            end else if (dac_ld) begin
                check_eq("R6 stray dac_ld", 1, 0);
            end
            if (mux_load) check_eq("R2 early mux_load", 1, 0);
        end
        check_eq("R6 R7 dac gain held", int'(dac_gain), last_g);
        check_eq("R6 R7 dac fine held", int'(dac_fine), last_f);
        @(negedge clk);
        prev_valid = 1;
        prev_ch = ch;
        prev_m = m;
        prev_ovr = ovr;
        exp_ptr = (exp_ptr >= int'(list_last)) ? 0 : exp_ptr + 1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 0 || i == 5) begin
                check_eq("R1 mux_load idle", int'(mux_load), 0);
                check_eq("R1 adc_start idle", int'(adc_start), 0);
                check_eq("R1 cal_rd idle", int'(cal_rd), 0);
                check_eq("R1 dac_ld idle", int'(dac_ld), 0);
                check_eq("R1 overrun idle", int'(overrun), 0);
                check_eq("R1 mux_ch idle", int'(mux_ch), 0);
                check_eq("R1 dac_gain idle", int'(dac_gain), 0);
            end
            check_eq("R1 range ignores range_under", int'(range_sel), 0);
        end
    endtask

    task automatic t_basic_scan();
        list_mem[0] = 6'd10; list_mem[1] = 6'd20; list_mem[2] = 6'd33; list_mem[3] = 6'd5;
        list_last = 6'd3;
        start_scan();
        repeat (9) step_cycle();
    endtask

    task automatic t_overrun();
        list_mem[0] = 6'd63; list_mem[1] = 6'd10; list_mem[2] = 6'd0;
        list_last = 6'd2;
        start_scan();
        repeat (5) step_cycle();
    endtask

    task automatic t_restart();
        list_mem[0] = 6'd20; list_mem[1] = 6'd33; list_mem[2] = 6'd10;
        list_last = 6'd2;
        start_scan();
        step_cycle();
        repeat (5) @(negedge clk);
        start_scan();
        repeat (3) step_cycle();
    endtask

    task automatic t_single_entry();
        list_mem[0] = 6'd5;
        list_last = 6'd0;
        start_scan();
        repeat (3) step_cycle();
    endtask

    initial begin
        for (int i = 0; i < N_CH; i++) lvl[i] = 4000;
        for (int i = 0; i < DEPTH; i++) list_mem[i] = '0;
        lvl[0]  = 0;
        lvl[10] = 3000;
        lvl[20] = 500;
        lvl[33] = 100;
        lvl[5]  = 20;
        lvl[63] = 0;
        t_reset();
        t_basic_scan();
        t_overrun();
        t_restart();
        t_single_entry();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule